// File: doc/BRIEF.md
# Quasi-Cyclic LDPC Accumulator Encoder

This block turns a fixed-size frame of information bits into a systematic rate-1/4 low-density parity-check codeword. The frame is 184 bits and the codeword is 736 bits. Information bits arrive one per cycle on a 1-bit valid/ready stream. A start marker flags the first bit of a frame. Each accepted bit goes straight to the output stream as part of the systematic section.

While each bit passes through, it is XORed into a 552-bit parity register. It lands at every address of one row of a base address table. Each group of 8 consecutive bits uses one table row. Bit m of a group has every base address shifted by m·69, wrapped into the range 0 to 551.

Once the frame is complete, the input stalls and the block streams out the 552 parity bits. Each emitted parity bit is the running XOR of the accumulated parity register from position 0 up to its own position. An end marker flags the final bit of the codeword.

The address table is a parameter, so an integrator can load a different table. The frame length, group size, row weight and shift step are also parameters. The parity length is always three times the frame length.

Top module: `ldpc_qc_encoder`

## Requirements
- R1: A codeword is exactly 184 + 552 = 736 output transfers. `out_last` is high on the 736th transfer of each codeword and on no other transfer.
- R2: The first 184 output transfers of a codeword carry the frame's information bits in arrival order, unchanged and in the same cycle they are accepted.
- R3: Information bit j (row r = j/8, position m = j mod 8) is XORed into the parity register at address (x + m·69) mod 552 for every entry x of table row r. The table is packed with entry e of row r at bit offset (r·10 + e)·10 of `ADDR_ROM`.
- R4: Parity output bit i (i = 0..551) equals the XOR of the accumulated parity register bits 0..i. The parity bits leave in increasing order of i.
- R5: The parity register is all zero when each frame begins, so a codeword never depends on an earlier frame.
- R6: From the 185th output transfer until the last parity bit has been taken, `in_ready` is low and no input beat is consumed, whatever `in_valid` and `in_sof` do.
- R7: Between frames, a beat with `in_sof` low is consumed (`in_ready` high) and produces no output. Inside a frame, `in_sof` has no effect and the beat is treated as ordinary data.
- R8: Backpressure. While the frame is being received, `in_ready` follows `out_ready`. While parity is streaming, a cycle with `out_ready` low holds `out_valid` high and keeps `out_data` and `out_last` unchanged into the next cycle.
- R9: After reset (synchronous, active low), the block waits for a start marker with `out_valid` low and `in_ready` high. A reset in the middle of a frame abandons that frame, and the next frame is encoded correctly.
- R10: With the default table, row 0 holds 1, 7, 90, 172, 209, 359, 401, 420, 483, 487. A frame whose only set bit is bit 1 therefore toggles parity addresses 70, 76, 159, 241, 278, 428, 470, 489, 0 and 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Information bit offered |
| in_data | input | 1 | Information bit |
| in_sof | input | 1 | Marks the first bit of a frame |
| in_ready | output | 1 | Input beat accepted when high together with `in_valid` |
| out_valid | output | 1 | Codeword bit offered |
| out_data | output | 1 | Codeword bit (systematic part, then parity) |
| out_last | output | 1 | High on the final bit of the codeword |
| out_ready | input | 1 | Downstream accepts the offered bit |

## Verification
The bench builds the block with its default parameters: 184-bit frames, groups of 8, ten addresses per row, a step of 69 and the built-in table. This makes the full 23-row walk reachable, including wrap-around of the shifted addresses past 551 and the row change at every eighth bit. It also exposes the known first-row addresses and their second-bit images, which the bench checks against constants. Framed vectors with single-bit, all-ones, all-zeros and pseudo-random frames are compared against a direct modulo-arithmetic model. These frames run with and without random output backpressure, with start markers inside frames, and with input beats offered during the parity phase.

// File: rtl/ldpc_enc_pkg.sv
`timescale 1ns/1ps
// Package: code constants for the default configuration, the controller
// phase type and the generator of the default base address table.
// Assumes the default table row weight is 10 (the fixed first row has 10 entries).
package ldpc_enc_pkg;

    localparam int DEF_K_BITS   = 184;
    localparam int DEF_GROUP    = 8;
    localparam int DEF_ROW_W    = 10;
    localparam int DEF_Q_STEP   = 69;
    localparam int DEF_M_BITS   = 3 * DEF_K_BITS;
    localparam int DEF_ROWS     = DEF_K_BITS / DEF_GROUP;
    localparam int DEF_AW       = $clog2(DEF_M_BITS);
    localparam int DEF_ROM_BITS = DEF_ROWS * DEF_ROW_W * DEF_AW;

    // Controller phase of the encoder.
    typedef enum logic [1:0] {
        ENC_IDLE   = 2'd0,
        ENC_INFO   = 2'd1,
        ENC_PARITY = 2'd2
    } enc_phase_e;

    // Default table: row 0 is fixed; the remaining rows are filled by an
    // arithmetic rule and are meant to be replaced through ADDR_ROM.
    function automatic logic [DEF_ROM_BITS-1:0] default_rom();
        logic [DEF_ROM_BITS-1:0] rom;
        int lead [DEF_ROW_W] = '{1, 7, 90, 172, 209, 359, 401, 420, 483, 487};
        int v;
        rom = '0;
        for (int r = 0; r < DEF_ROWS; r++) begin
            for (int e = 0; e < DEF_ROW_W; e++) begin
                if (r == 0) v = lead[e];
                else        v = (lead[e] + 97 * r + 31 * r * e + 13 * e * e) % DEF_M_BITS;
                rom[(r * DEF_ROW_W + e) * DEF_AW +: DEF_AW] = DEF_AW'(v);
            end
        end
        return rom;
    endfunction

endpackage

// File: rtl/ldpc_addr_gen.sv
`timescale 1ns/1ps
// Parity address generator.
// Holds the ROW_W parity addresses for the next information bit to be
// accepted. At the start of each group it loads the base row from the
// table. Within a group it adds Q_STEP with one conditional subtract of M_BITS.
// Assumes Q_STEP < M_BITS, all table entries < M_BITS and K divisible by
// GROUP, so that the last bit of a frame returns the row pointer to row 0.
module ldpc_addr_gen #(
    parameter int M_BITS  = 552,
    parameter int Q_STEP  = 69,
    parameter int ROWS    = 23,
    parameter int ROW_W   = 10,
    parameter int GROUP   = 8,
    parameter int AW      = 10,
    parameter logic [ROWS*ROW_W*AW-1:0] ADDR_ROM = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       step,
    output logic [ROW_W-1:0][AW-1:0]   addr
);
    localparam int RW = (ROWS  > 1) ? $clog2(ROWS)  : 1;
    localparam int GW = (GROUP > 1) ? $clog2(GROUP) : 1;

    logic [RW-1:0]              row_q, row_nx;
    logic [GW-1:0]              pos_q;
    logic [ROW_W-1:0][AW-1:0]   addr_q, base_nx, shift_nx, base_first;

    // Next table row, wrapping after the last row of the frame.
    always_comb row_nx = (row_q == RW'(ROWS - 1)) ? '0 : row_q + 1'b1;

    for (genvar e = 0; e < ROW_W; e++) begin : g_entry
        logic [AW:0] sum;
        // Shift by one step inside the group, folded back below M_BITS.
        assign sum          = {1'b0, addr_q[e]} + (AW+1)'(Q_STEP);
        assign shift_nx[e]  = (sum >= (AW+1)'(M_BITS)) ? AW'(sum - (AW+1)'(M_BITS))
                                                       : sum[AW-1:0];
        // Base entry of the next row and of row 0.
        assign base_nx[e]    = ADDR_ROM[(int'(row_nx) * ROW_W + e) * AW +: AW];
        assign base_first[e] = ADDR_ROM[e * AW +: AW];
    end

    // Advance position, row and addresses on every accepted information bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q  <= '0;
            pos_q  <= '0;
            addr_q <= base_first;
        end else if (step) begin
            if (pos_q == GW'(GROUP - 1)) begin
                pos_q  <= '0;
                row_q  <= row_nx;
                addr_q <= base_nx;
            end else begin
                pos_q  <= pos_q + 1'b1;
                addr_q <= shift_nx;
            end
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/ldpc_parity_acc.sv
`timescale 1ns/1ps
// Parity accumulator and staircase output.
// In accumulate mode a set information bit flips the register at every
// address in 'addr'. In shift mode the register moves toward bit 0, and a
// running XOR turns each raw parity bit into its staircase value on the way out.
// Assumes the two modes are never requested in the same cycle.
// The register drains to zero as it shifts, so it is clear for the next frame.
module ldpc_parity_acc #(
    parameter int M_BITS = 552,
    parameter int ROW_W  = 10,
    parameter int AW     = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       acc_en,
    input  logic                       acc_bit,
    input  logic [ROW_W-1:0][AW-1:0]   addr,
    input  logic                       shift_en,
    input  logic                       shift_last,
    output logic                       par_bit
);
    logic [M_BITS-1:0] preg_q, flip_mask;
    logic              run_q;

    // Decode the row of addresses into a flip mask (repeats cancel).
    always_comb begin
        flip_mask = '0;
        for (int e = 0; e < ROW_W; e++) begin
            flip_mask[addr[e]] = ~flip_mask[addr[e]];
        end
    end

    // Staircase value of the parity bit at the head of the register.
    assign par_bit = run_q ^ preg_q[0];

    // Accumulate, or shift out with the running XOR.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preg_q <= '0;
            run_q  <= 1'b0;
        end else if (acc_en) begin
            if (acc_bit) preg_q <= preg_q ^ flip_mask;
        end else if (shift_en) begin
            preg_q <= {1'b0, preg_q[M_BITS-1:1]};
            run_q  <= shift_last ? 1'b0 : par_bit;
        end
    end

endmodule

// File: rtl/ldpc_enc_ctrl.sv
`timescale 1ns/1ps
// Encoder controller.
// Sequences idle (waiting for a start marker), information pass-through and
// parity streaming. It derives both handshakes and the step strobes for the
// address generator and the parity accumulator.
// Assumes out_ready is a plain input with no dependency on out_valid.
module ldpc_enc_ctrl #(
    parameter int K_BITS = 184,
    parameter int M_BITS = 552
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sof,
    output logic in_ready,
    input  logic out_ready,
    output logic out_valid,
    output logic out_last,
    output logic sel_parity,
    output logic info_step,
    output logic par_step,
    output logic par_last
);
    import ldpc_enc_pkg::*;

    localparam int CMAX = (K_BITS > M_BITS) ? K_BITS : M_BITS;
    localparam int CW   = $clog2(CMAX);

    enc_phase_e     phase_q;
    logic [CW-1:0]  cnt_q;
    logic           at_info_end, at_par_end;

    assign at_info_end = (cnt_q == CW'(K_BITS - 1));
    assign at_par_end  = (cnt_q == CW'(M_BITS - 1));

    // Handshake and strobe decode for the current phase.
    always_comb begin
        in_ready   = 1'b0;
        out_valid  = 1'b0;
        info_step  = 1'b0;
        par_step   = 1'b0;
        sel_parity = 1'b0;
        unique case (phase_q)
            ENC_IDLE: begin
                in_ready  = in_sof ? out_ready : 1'b1;
                out_valid = in_valid & in_sof;
                info_step = in_valid & in_sof & out_ready;
            end
            ENC_INFO: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                info_step = in_valid & out_ready;
            end
            ENC_PARITY: begin
                out_valid  = 1'b1;
                sel_parity = 1'b1;
                par_step   = out_ready;
            end
            default: ;
        endcase
        par_last = sel_parity & at_par_end;
        out_last = par_last;
    end

    // Phase and bit counter sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= ENC_IDLE;
            cnt_q   <= '0;
        end else if (info_step) begin
            if (at_info_end) begin
                phase_q <= ENC_PARITY;
                cnt_q   <= '0;
            end else begin
                phase_q <= ENC_INFO;
                cnt_q   <= cnt_q + 1'b1;
            end
        end else if (par_step) begin
            if (at_par_end) begin
                phase_q <= ENC_IDLE;
                cnt_q   <= '0;
            end else begin
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ldpc_qc_encoder.sv
`timescale 1ns/1ps
// Systematic rate-1/4 quasi-cyclic LDPC encoder (top).
// Passes information bits through and accumulates them into the parity
// register, then streams the staircase parity.
// Assumes K_BITS is a multiple of GROUP, Q_STEP < 3*K_BITS, and that
// ADDR_ROM holds ROWS*ROW_W entries of AW bits, each below 3*K_BITS.
module ldpc_qc_encoder #(
    parameter int K_BITS = ldpc_enc_pkg::DEF_K_BITS,
    parameter int GROUP  = ldpc_enc_pkg::DEF_GROUP,
    parameter int ROW_W  = ldpc_enc_pkg::DEF_ROW_W,
    parameter int Q_STEP = ldpc_enc_pkg::DEF_Q_STEP,
    localparam int M_BITS = 3 * K_BITS,
    localparam int ROWS   = K_BITS / GROUP,
    localparam int AW     = $clog2(M_BITS),
    parameter logic [ROWS*ROW_W*AW-1:0] ADDR_ROM = ldpc_enc_pkg::default_rom()
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_data,
    input  logic in_sof,
    output logic in_ready,
    output logic out_valid,
    output logic out_data,
    output logic out_last,
    input  logic out_ready
);
    localparam int N_BITS = K_BITS + M_BITS;

    logic                      sel_parity, info_step, par_step, par_last, par_bit;
    logic [ROW_W-1:0][AW-1:0]  addr;

    ldpc_enc_ctrl #(
        .K_BITS (K_BITS),
        .M_BITS (M_BITS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .in_ready   (in_ready),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_last   (out_last),
        .sel_parity (sel_parity),
        .info_step  (info_step),
        .par_step   (par_step),
        .par_last   (par_last)
    );

    ldpc_addr_gen #(
        .M_BITS   (M_BITS),
        .Q_STEP   (Q_STEP),
        .ROWS     (ROWS),
        .ROW_W    (ROW_W),
        .GROUP    (GROUP),
        .AW       (AW),
        .ADDR_ROM (ADDR_ROM)
    ) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (info_step),
        .addr  (addr)
    );

    ldpc_parity_acc #(
        .M_BITS (M_BITS),
        .ROW_W  (ROW_W),
        .AW     (AW)
    ) u_par (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_en     (info_step),
        .acc_bit    (in_data),
        .addr       (addr),
        .shift_en   (par_step),
        .shift_last (par_last),
        .par_bit    (par_bit)
    );

    // Output mux: systematic bit while receiving, staircase parity afterwards.
    assign out_data = sel_parity ? par_bit : in_data;

endmodule

// File: rtl/ldpc_enc_checker.sv
`timescale 1ns/1ps
// Protocol checker for the encoder. It keeps its own count of output transfers
// within a codeword and checks framing, pass-through, input stalling and
// backpressure at the ports.
module ldpc_enc_checker #(
    parameter int K_BITS = 184,
    parameter int N_BITS = 736
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_data,
    input logic in_sof,
    input logic in_ready,
    input logic out_valid,
    input logic out_data,
    input logic out_last,
    input logic out_ready
);
    localparam int CW = $clog2(N_BITS);

    logic [CW-1:0] ocnt;
    logic          in_par;

    // Count output transfers within the current codeword.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ocnt <= '0;
        else if (out_valid && out_ready)
            ocnt <= (ocnt == CW'(N_BITS - 1)) ? '0 : ocnt + 1'b1;
    end

    assign in_par = (ocnt >= CW'(K_BITS));

    // R1: the end marker appears exactly on the final transfer.
    assert_last_on_final_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (ocnt == CW'(N_BITS - 1)));
    assert_final_has_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ocnt == CW'(N_BITS - 1)) |-> out_last);

    // R2: systematic section mirrors the input beat.
    assert_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !in_par) |-> (in_valid && out_data == in_data));

    // R6: no input accepted while parity streams.
    assert_input_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_par |-> !in_ready);

    // R7: stray beats between frames produce no output.
    assert_stray_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ocnt == '0 && in_valid && !in_sof) |-> !out_valid);

    // R8: a stalled parity bit is held unchanged.
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && in_par) |=>
            (out_valid && $stable(out_data) && $stable(out_last)));

endmodule

bind ldpc_qc_encoder ldpc_enc_checker #(
    .K_BITS (K_BITS),
    .N_BITS (N_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_sof    (in_sof),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_ready (out_ready)
);

// File: tb/ldpc_qc_encoder_test.sv
`timescale 1ns/1ps
// Bench for the LDPC encoder at default parameters: a vector table of frames
// compared against a modulo-arithmetic model, then directed tests.
module ldpc_qc_encoder_test;
    import ldpc_enc_pkg::*;

    localparam int K = DEF_K_BITS;
    localparam int M = DEF_M_BITS;
    localparam int N = K + M;
    localparam logic [DEF_ROM_BITS-1:0] ROM = default_rom();
    localparam int ROW0_ADDR [10] = '{1, 7, 90, 172, 209, 359, 401, 420, 483, 487};
    localparam int BIT1_ADDR [10] = '{70, 76, 159, 241, 278, 428, 470, 489, 0, 4};

    typedef struct packed {
        logic [1:0]  kind;    // 0 zeros, 1 single bit at seed, 2 pseudo-random, 3 ones
        logic [15:0] seed;
        logic        stall;   // random out_ready
        logic        sofall;  // start marker on every bit
        logic        poke;    // offer beats during parity phase
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 16'hACE1, 1'b0, 1'b0, 1'b0},
        '{2'd2, 16'h1234, 1'b1, 1'b0, 1'b0},
        '{2'd3, 16'h0000, 1'b0, 1'b0, 1'b0},
        '{2'd1, 16'd183,  1'b0, 1'b0, 1'b0},
        '{2'd1, 16'd100,  1'b1, 1'b0, 1'b1},
        '{2'd2, 16'h0F0F, 1'b0, 1'b1, 1'b0},
        '{2'd0, 16'h0000, 1'b0, 1'b0, 1'b1},
        '{2'd2, 16'h7777, 1'b1, 1'b1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_data = 1'b0, in_sof = 1'b0, out_ready = 1'b0;
    logic in_ready, out_valid, out_data, out_last;

    int n_checks = 0;
    int n_fail   = 0;
    logic [N-1:0] got;

    always #2 clk = ~clk;

    ldpc_qc_encoder uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_sof    (in_sof),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .out_ready (out_ready)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference codeword by direct modulo arithmetic and prefix XOR.
    function automatic logic [N-1:0] model(input logic [K-1:0] b);
        logic [M-1:0] p = '0;
        logic [N-1:0] cw;
        logic run = 1'b0;
        for (int j = 0; j < K; j++) begin
            if (b[j]) begin
                for (int e = 0; e < DEF_ROW_W; e++) begin
                    int x = int'(ROM[((j / DEF_GROUP) * DEF_ROW_W + e) * DEF_AW +: DEF_AW]);
                    p[(x + (j % DEF_GROUP) * DEF_Q_STEP) % M] ^= 1'b1;
                end
            end
        end
        cw[K-1:0] = b;
        for (int i = 0; i < M; i++) begin
            run = run ^ p[i];
            cw[K+i] = run;
        end
        return cw;
    endfunction

    function automatic logic [K-1:0] pattern(input vec_t v);
        logic [K-1:0] b = '0;
        logic [31:0] s = {16'h5A5A, v.seed} | 32'd1;
        for (int j = 0; j < K; j++) begin
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            case (v.kind)
                2'd0: b[j] = 1'b0;
                2'd1: b[j] = (j == int'(v.seed) % K);
                2'd2: b[j] = s[0];
                default: b[j] = 1'b1;
            endcase
        end
        return b;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive one frame, collect the codeword into 'got' and compare with the model.
    task automatic run_frame(input logic [K-1:0] b, input bit stall,
                             input bit sofall, input bit poke);
        int idx = 0, oc = 0, cyc = 0;
        bit hold = 1'b0, last_bad = 1'b0, r6_bad = 1'b0, r8_bad = 1'b0, rdy_bad = 1'b0;
        logic hd = 1'b0, hl = 1'b0;
        logic [N-1:0] exp;
        int nbad;
        while (oc < N && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (idx < K) begin
                in_valid = 1'b1; in_data = b[idx]; in_sof = (idx == 0) || sofall;
            end else begin
                in_valid = poke; in_sof = poke; in_data = 1'b1;
            end
            out_ready = stall ? ($urandom_range(0, 2) != 0) : 1'b1;
            #1;
            if (hold && !(out_valid && out_data == hd && out_last == hl)) r8_bad = 1'b1;
            if (idx < K && in_ready != out_ready) rdy_bad = 1'b1;
            if (idx >= K && in_ready) r6_bad = 1'b1;
            hold = out_valid && !out_ready && (idx >= K);
            hd = out_data; hl = out_last;
            if (out_valid && out_ready) begin
                got[oc] = out_data;
                if (out_last != (oc == N - 1)) last_bad = 1'b1;
                oc++;
            end
            if (in_valid && in_ready && idx < K) idx++;
        end
        check(oc == N, "R1", "codeword transfers", oc, N);
        check(!last_bad, "R1", "end marker misplaced", last_bad, 0);
        if (stall) begin
            check(!r8_bad, "R8", "stalled parity not held", r8_bad, 0);
            check(!rdy_bad, "R8", "in_ready vs out_ready in frame", rdy_bad, 0);
        end
        if (poke) check(!r6_bad, "R6", "input accepted in parity phase", r6_bad, 0);
        exp = model(b);
        nbad = 0;
        for (int i = 0; i < K; i++) if (got[i] !== exp[i]) nbad++;
        check(nbad == 0, "R2", "systematic bits wrong", nbad, 0);
        nbad = 0;
        for (int i = K; i < N; i++) if (got[i] !== exp[i]) nbad++;
        check(nbad == 0, "R3 R4", "parity bits wrong", nbad, 0);
    endtask

    // Undo the staircase on 'got' and compare set positions with a list.
    task automatic check_raw(input int lst [10], input string what);
        int nbad = 0;
        for (int i = 0; i < M; i++) begin
            logic raw = got[K+i] ^ ((i > 0) ? got[K+i-1] : 1'b0);
            bit want = 1'b0;
            for (int e = 0; e < 10; e++) if (lst[e] == i) want = 1'b1;
            if (raw != want) nbad++;
        end
        check(nbad == 0, "R10", what, nbad, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [K-1:0] b;
        do_reset();
        // R9: idle after reset.
        @(negedge clk); #1;
        check(!out_valid, "R9", "out_valid after reset", out_valid, 0);
        check(in_ready, "R9", "in_ready after reset", in_ready, 1);

        // R7: stray beats between frames are consumed silently.
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = 1'b0; in_data = 1'b1; out_ready = 1'b1;
            #1;
            check(in_ready && !out_valid, "R7", "stray beat handling",
                  {in_ready, out_valid}, 2);
        end

        // Vector table walk.
        for (int v = 0; v < NV; v++) begin
            run_frame(pattern(VECS[v]), VECS[v].stall, VECS[v].sofall, VECS[v].poke);
        end

        // R10: first-row addresses and their second-bit images.
        b = '0; b[0] = 1'b1;
        run_frame(b, 1'b0, 1'b0, 1'b0);
        check_raw(ROW0_ADDR, "bit 0 parity positions");
        b = '0; b[1] = 1'b1;
        run_frame(b, 1'b0, 1'b0, 1'b0);
        check_raw(BIT1_ADDR, "bit 1 parity positions");

        // R5: an all-zero frame after an all-ones frame has zero parity.
        run_frame('1, 1'b0, 1'b0, 1'b0);
        run_frame('0, 1'b0, 1'b0, 1'b0);
        check(got[N-1:K] == '0, "R5", "parity after prior frame", $countones(got[N-1:K]), 0);

        // R9: reset in the middle of a frame, then a clean frame.
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (c == 0); in_data = c[0]; out_ready = 1'b1;
        end
        do_reset();
        @(negedge clk); #1;
        check(!out_valid && in_ready, "R9", "idle after mid-frame reset",
              {out_valid, in_ready}, 1);
        run_frame(pattern('{2'd2, 16'hBEEF, 1'b1, 1'b0, 1'b0}), 1'b1, 1'b0, 1'b0);

        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule